// File: doc/BRIEF.md
# Harmonic Bin Search and Spectral Power Accumulator

This block works through a one-sided magnitude spectrum of `NBINS` bins that sits in an external synchronous RAM. Once started with the bin index of the fundamental and a harmonic count, it visits every requested harmonic. For each one it computes where the harmonic should land once aliased back into the first Nyquist zone, and looks around that spot for the real peak. It then walks down both flanks of the peak to the valleys. The squared magnitudes over that span give the harmonic's power, doubled to account for the discarded half of the spectrum.

When the harmonics are done, a final pass over the spectrum totals the power of every non-DC bin. The same pass finds the strongest bin that lies outside the fundamental's span, which is the worst spur. All results are held in registers and a done flag marks them valid. They are the raw inputs of the distortion and noise figures computed further downstream. This block forms no logarithms and no ratios.

Top module: `harmonic_power_scan`

## Requirements
- R1: While reset is high and on the cycle after it, `done` is 0, every power, peak, span and spur output is 0, and `rd_addr` is 1.
- R2: `rd_addr` always lies in 1..NBINS-1, so bin 0 (DC) is never read. The RAM returns `rd_data` one clock after it samples `rd_addr`.
- R3: For harmonic h, with fundamental bin f and NBINS a power of two, k = (h*f) mod (2*NBINS). The expected bin is e = k when k <= NBINS, and 2*NBINS-k otherwise.
- R4: The peak is the largest bin in max(e-5,1)..min(e+5,NBINS-1). On equal values the lowest index wins. Harmonic h's peak index is reported in field h-1 of `harm_peak`.
- R5: The span of a harmonic grows from its peak one bin at a time, downward while the next lower bin is strictly smaller than the current one (never below bin 1), and upward in the same way (never above NBINS-1). The fundamental's span ends are reported on `fund_lo` and `fund_hi`.
- R6: A harmonic's power, in field h-1 of `harm_pow`, is twice the sum of the squared magnitudes over its span.
- R7: A harmonic whose peak index equals the peak index of an earlier harmonic in the same run reports power 0, and that power adds nothing to `harm_sum`.
- R8: `sig_pow` equals the power of harmonic 1, and `harm_sum` is the sum of the powers of harmonics 2 up to the count. Fields of harmonics beyond the count read 0 for both power and peak.
- R9: A `harm_cnt` of 0 is treated as 1, and values above H_MAX are treated as H_MAX.
- R10: `total_pow` is twice the sum of squared magnitudes over bins 1..NBINS-1. Bin 0 is left out.
- R11: `spur_mag` and `spur_bin` give the largest bin in 1..NBINS-1 outside `fund_lo`..`fund_hi`, with the lowest index winning ties. If no such bin is non-zero, both are 0.
- R12: `done` rises once all outputs are final. It and all outputs then hold until the next `start`, which clears them. A `start` raised while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (one-cycle pulse) |
| fund_bin | input | BW | Bin index of the fundamental |
| harm_cnt | input | HW | Number of harmonics to examine |
| rd_addr | output | BW | Spectrum RAM read address |
| rd_data | input | MAG_W | Spectrum RAM read data, one cycle latency |
| done | output | 1 | Results valid |
| harm_pow | output | H_MAX*OW | Doubled power per harmonic, harmonic 1 in the low field |
| harm_peak | output | H_MAX*BW | Peak bin per harmonic |
| sig_pow | output | OW | Power of harmonic 1 |
| harm_sum | output | SW | Summed power of harmonics 2 up to the count |
| total_pow | output | OW | Doubled power of all non-DC bins |
| spur_mag | output | MAG_W | Worst spur magnitude |
| spur_bin | output | BW | Worst spur bin |
| fund_lo | output | BW | Lower end of the fundamental's span |
| fund_hi | output | BW | Upper end of the fundamental's span |

## Verification
Shaped tones at a low fundamental with all nine harmonics test peak search, valley walking and power sums on unaliased bins. A fundamental high in the band shows whether harmonics fold back to the correct bins. A fundamental at a quarter of the band makes harmonics land on the Nyquist edge, at DC and back on the fundamental, which exercises window clipping and the zeroing of repeated peaks. A flat spectrum separates lowest-index tie breaking from other orders and proves that a plateau is not walked. Random spectra with random counts, including 0 and counts above the limit, cover the clamping. A large DC bin shows it is kept out of the total.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_SRCH,
    ST_WINIT,
    ST_DOWN,
    ST_UINIT,
    ST_UP,
    ST_STORE,
    ST_SCAN,
    ST_DONE
  } hb_state_t;
endpackage

// File: rtl/hb_fold.sv
module hb_fold #(
  parameter int NBINS = 64,
  parameter int BW    = 6,
  parameter int HW    = 4,
  parameter int SRCH  = 5
) (
  input  logic [BW-1:0] fund,
  input  logic [HW-1:0] hnum,
  output logic [BW-1:0] win_lo,
  output logic [BW-1:0] win_hi
);
  localparam int XW = BW + 2;
  localparam logic [XW-1:0] NB_X   = XW'(NBINS);
  localparam logic [XW-1:0] TWO_NB = XW'(2 * NBINS);
  localparam logic [XW-1:0] LAST_X = XW'(NBINS - 1);
  localparam logic [XW-1:0] SR_X   = XW'(SRCH);

  logic [BW+HW-1:0] prod;
  logic [XW-1:0]    k;
  logic [XW-1:0]    e;
  logic [XW-1:0]    lo_x;
  logic [XW-1:0]    hi_x;

  always_comb begin
    prod = BW'(fund) * hnum;
    k    = {1'b0, prod[BW:0]};
    e    = (k > NB_X) ? (TWO_NB - k) : k;
    lo_x = (e <= SR_X + XW'(1)) ? XW'(1) : (e - SR_X);
    hi_x = (e + SR_X >= LAST_X) ? LAST_X : (e + SR_X);
  end

  assign win_lo = lo_x[BW-1:0];
  assign win_hi = hi_x[BW-1:0];
endmodule

// File: rtl/hb_square.sv
module hb_square #(
  parameter int W = 12
) (
  input  logic [W-1:0]   a,
  output logic [2*W-1:0] y
);
  assign y = a * a;
endmodule

// File: rtl/hb_engine.sv
module hb_engine
  import hb_pkg::*;
#(
  parameter int NBINS = 64,
  parameter int MAG_W = 12,
  parameter int H_MAX = 9,
  parameter int BW    = 6,
  parameter int HW    = 4,
  parameter int AW    = 30,
  parameter int OW    = 31,
  parameter int SW    = 35
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [BW-1:0]      fund_bin,
  input  logic [HW-1:0]      harm_cnt,
  input  logic [MAG_W-1:0]   rd_data,
  input  logic [2*MAG_W-1:0] sq_data,
  input  logic [2*MAG_W-1:0] sq_best,
  input  logic [BW-1:0]      win_lo,
  input  logic [BW-1:0]      win_hi,
  output logic [BW-1:0]      rd_addr,
  output logic [BW-1:0]      cur_fund,
  output logic [HW-1:0]      cur_h,
  output logic [MAG_W-1:0]   best_mag,
  output logic               done,
  output logic [H_MAX*OW-1:0] harm_pow,
  output logic [H_MAX*BW-1:0] harm_peak,
  output logic [OW-1:0]      sig_pow,
  output logic [SW-1:0]      harm_sum,
  output logic [OW-1:0]      total_pow,
  output logic [MAG_W-1:0]   spur_mag,
  output logic [BW-1:0]      spur_bin,
  output logic [BW-1:0]      fund_lo,
  output logic [BW-1:0]      fund_hi
);
  localparam logic [BW-1:0] LAST  = BW'(NBINS - 1);
  localparam logic [BW-1:0] LAST2 = BW'(NBINS - 2);
  localparam logic [BW-1:0] ONE   = BW'(1);
  localparam logic [HW-1:0] HMAXV = HW'(H_MAX);

  hb_state_t state, ret;
  logic [HW-1:0]    h, cnt_q;
  logic [BW-1:0]    fund_q, idx, best_bin, lo_e, hi_e, flo, fhi, spb, addr_q;
  logic [MAG_W-1:0] best, cur, spm;
  logic             first, done_q;
  logic [AW-1:0]    acc, tot;
  logic [SW-1:0]    hsum;
  logic [OW-1:0]    sig_q;
  logic [OW-1:0]    pow_r  [H_MAX];
  logic [BW-1:0]    peak_r [H_MAX];
  logic             dup;
  logic [HW-1:0]    cnt_clamped;
  logic [OW-1:0]    pow_new;

  always_comb begin
    if (harm_cnt == '0)        cnt_clamped = HW'(1);
    else if (harm_cnt > HMAXV) cnt_clamped = HMAXV;
    else                       cnt_clamped = harm_cnt;
  end

  always_comb begin
    dup = 1'b0;
    for (int j = 0; j < H_MAX; j++) begin
      if ((j + 1) < int'(h) && peak_r[j] == best_bin) dup = 1'b1;
    end
    pow_new = dup ? '0 : {acc, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ret      <= ST_IDLE;
      h        <= '0;
      cnt_q    <= '0;
      fund_q   <= '0;
      idx      <= '0;
      best     <= '0;
      best_bin <= '0;
      first    <= 1'b0;
      lo_e     <= '0;
      hi_e     <= '0;
      cur      <= '0;
      acc      <= '0;
      tot      <= '0;
      hsum     <= '0;
      sig_q    <= '0;
      spm      <= '0;
      spb      <= '0;
      flo      <= '0;
      fhi      <= '0;
      done_q   <= 1'b0;
      addr_q   <= ONE;
      for (int j = 0; j < H_MAX; j++) begin
        pow_r[j]  <= '0;
        peak_r[j] <= '0;
      end
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            fund_q <= fund_bin;
            cnt_q  <= cnt_clamped;
            h      <= HW'(1);
            tot    <= '0;
            hsum   <= '0;
            sig_q  <= '0;
            spm    <= '0;
            spb    <= '0;
            flo    <= '0;
            fhi    <= '0;
            done_q <= 1'b0;
            for (int j = 0; j < H_MAX; j++) begin
              pow_r[j]  <= '0;
              peak_r[j] <= '0;
            end
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          idx    <= win_lo;
          addr_q <= win_lo;
          first  <= 1'b1;
          ret    <= ST_SRCH;
          state  <= ST_WAIT;
        end
        ST_WAIT: state <= ret;
        ST_SRCH: begin
          if (first || rd_data > best) begin
            best     <= rd_data;
            best_bin <= idx;
          end
          first <= 1'b0;
          if (idx == win_hi) begin
            state <= ST_WINIT;
          end else begin
            idx    <= idx + ONE;
            addr_q <= idx + ONE;
            state  <= ST_WAIT;
          end
        end
        ST_WINIT: begin
          acc  <= AW'(sq_best);
          lo_e <= best_bin;
          cur  <= best;
          if (best_bin > ONE) begin
            addr_q <= best_bin - ONE;
            ret    <= ST_DOWN;
            state  <= ST_WAIT;
          end else begin
            state <= ST_UINIT;
          end
        end
        ST_DOWN: begin
          if (rd_data < cur) begin
            acc  <= acc + AW'(sq_data);
            lo_e <= lo_e - ONE;
            cur  <= rd_data;
            if (lo_e > BW'(2)) begin
              addr_q <= lo_e - BW'(2);
              state  <= ST_WAIT;
            end else begin
              state <= ST_UINIT;
            end
          end else begin
            state <= ST_UINIT;
          end
        end
        ST_UINIT: begin
          hi_e <= best_bin;
          cur  <= best;
          if (best_bin < LAST) begin
            addr_q <= best_bin + ONE;
            ret    <= ST_UP;
            state  <= ST_WAIT;
          end else begin
            state <= ST_STORE;
          end
        end
        ST_UP: begin
          if (rd_data < cur) begin
            acc  <= acc + AW'(sq_data);
            hi_e <= hi_e + ONE;
            cur  <= rd_data;
            if (hi_e < LAST2) begin
              addr_q <= hi_e + BW'(2);
              state  <= ST_WAIT;
            end else begin
              state <= ST_STORE;
            end
          end else begin
            state <= ST_STORE;
          end
        end
        ST_STORE: begin
          pow_r[h - HW'(1)]  <= pow_new;
          peak_r[h - HW'(1)] <= best_bin;
          if (h == HW'(1)) begin
            sig_q <= pow_new;
            flo   <= lo_e;
            fhi   <= hi_e;
          end else begin
            hsum <= hsum + SW'(pow_new);
          end
          if (h == cnt_q) begin
            idx    <= ONE;
            addr_q <= ONE;
            ret    <= ST_SCAN;
            state  <= ST_WAIT;
          end else begin
            h     <= h + HW'(1);
            state <= ST_SETUP;
          end
        end
        ST_SCAN: begin
          tot <= tot + AW'(sq_data);
          if ((idx < flo || idx > fhi) && rd_data > spm) begin
            spm <= rd_data;
            spb <= idx;
          end
          if (idx == LAST) begin
            done_q <= 1'b1;
            state  <= ST_DONE;
          end else begin
            idx    <= idx + ONE;
            addr_q <= idx + ONE;
            state  <= ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < H_MAX; g++) begin : g_flat
    assign harm_pow[g*OW +: OW]  = pow_r[g];
    assign harm_peak[g*BW +: BW] = peak_r[g];
  end

  assign rd_addr   = addr_q;
  assign cur_fund  = fund_q;
  assign cur_h     = h;
  assign best_mag  = best;
  assign done      = done_q;
  assign sig_pow   = sig_q;
  assign harm_sum  = hsum;
  assign total_pow = {tot, 1'b0};
  assign spur_mag  = spm;
  assign spur_bin  = spb;
  assign fund_lo   = flo;
  assign fund_hi   = fhi;
endmodule

// File: rtl/harmonic_power_scan.sv
module harmonic_power_scan #(
  parameter int NBINS = 64,
  parameter int MAG_W = 12,
  parameter int H_MAX = 9,
  parameter int SRCH  = 5,
  localparam int BW   = $clog2(NBINS),
  localparam int HW   = $clog2(H_MAX + 1),
  localparam int AW   = 2 * MAG_W + BW,
  localparam int OW   = AW + 1,
  localparam int SW   = OW + HW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [BW-1:0]       fund_bin,
  input  logic [HW-1:0]       harm_cnt,
  output logic [BW-1:0]       rd_addr,
  input  logic [MAG_W-1:0]    rd_data,
  output logic                done,
  output logic [H_MAX*OW-1:0] harm_pow,
  output logic [H_MAX*BW-1:0] harm_peak,
  output logic [OW-1:0]       sig_pow,
  output logic [SW-1:0]       harm_sum,
  output logic [OW-1:0]       total_pow,
  output logic [MAG_W-1:0]    spur_mag,
  output logic [BW-1:0]       spur_bin,
  output logic [BW-1:0]       fund_lo,
  output logic [BW-1:0]       fund_hi
);
  logic [BW-1:0]      cur_fund, win_lo, win_hi;
  logic [HW-1:0]      cur_h;
  logic [MAG_W-1:0]   best_mag;
  logic [2*MAG_W-1:0] sq_data, sq_best;

  hb_fold #(.NBINS(NBINS), .BW(BW), .HW(HW), .SRCH(SRCH)) u_fold (
    .fund(cur_fund), .hnum(cur_h), .win_lo(win_lo), .win_hi(win_hi)
  );

  hb_square #(.W(MAG_W)) u_sq_data (.a(rd_data),  .y(sq_data));
  hb_square #(.W(MAG_W)) u_sq_best (.a(best_mag), .y(sq_best));

  hb_engine #(
    .NBINS(NBINS), .MAG_W(MAG_W), .H_MAX(H_MAX), .BW(BW), .HW(HW),
    .AW(AW), .OW(OW), .SW(SW)
  ) u_engine (
    .clk(clk), .rst(rst), .start(start), .fund_bin(fund_bin),
    .harm_cnt(harm_cnt), .rd_data(rd_data), .sq_data(sq_data),
    .sq_best(sq_best), .win_lo(win_lo), .win_hi(win_hi),
    .rd_addr(rd_addr), .cur_fund(cur_fund), .cur_h(cur_h),
    .best_mag(best_mag), .done(done), .harm_pow(harm_pow),
    .harm_peak(harm_peak), .sig_pow(sig_pow), .harm_sum(harm_sum),
    .total_pow(total_pow), .spur_mag(spur_mag), .spur_bin(spur_bin),
    .fund_lo(fund_lo), .fund_hi(fund_hi)
  );
endmodule

// File: rtl/hb_checker.sv
module hb_checker #(
  parameter int NBINS = 64,
  parameter int MAG_W = 12,
  parameter int BW    = 6,
  parameter int OW    = 31,
  parameter int SW    = 35
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [BW-1:0]    rd_addr,
  input logic             done,
  input logic [BW-1:0]    harm_peak0,
  input logic [OW-1:0]    sig_pow,
  input logic [SW-1:0]    harm_sum,
  input logic [OW-1:0]    total_pow,
  input logic [MAG_W-1:0] spur_mag,
  input logic [BW-1:0]    spur_bin,
  input logic [BW-1:0]    fund_lo,
  input logic [BW-1:0]    fund_hi
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!done && total_pow == '0 && sig_pow == '0 && rd_addr == BW'(1)));

  p_addr_range_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_addr != '0 && rd_addr <= BW'(NBINS - 1)));

  p_peak_in_span_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (fund_lo <= harm_peak0 && harm_peak0 <= fund_hi));

  p_doubled_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (sig_pow[0] == 1'b0 && harm_sum[0] == 1'b0 && total_pow[0] == 1'b0));

  p_spur_outside_r11: assert property (@(posedge clk) disable iff (rst)
    (done && spur_mag != '0) |-> (spur_bin < fund_lo || spur_bin > fund_hi));

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(total_pow) && $stable(spur_bin) && $stable(sig_pow)));

  p_done_drop_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(start));
endmodule

bind harmonic_power_scan hb_checker #(
  .NBINS(NBINS), .MAG_W(MAG_W), .BW(BW), .OW(OW), .SW(SW)
) u_hb_checker (
  .clk(clk), .rst(rst), .start(start), .rd_addr(rd_addr), .done(done),
  .harm_peak0(harm_peak[BW-1:0]), .sig_pow(sig_pow), .harm_sum(harm_sum),
  .total_pow(total_pow), .spur_mag(spur_mag), .spur_bin(spur_bin),
  .fund_lo(fund_lo), .fund_hi(fund_hi)
);

// File: tb/test_harmonic_power_scan.sv
module test_harmonic_power_scan;
  localparam int NB = 64;
  localparam int MW = 12;
  localparam int H  = 9;
  localparam int BW = 6;
  localparam int HW = 4;
  localparam int OW = 2 * MW + BW + 1;
  localparam int SW = OW + HW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [BW-1:0] fund_bin = '0;
  logic [HW-1:0] harm_cnt = '0;
  logic [BW-1:0] rd_addr;
  logic [MW-1:0] rd_data;
  logic done;
  logic [H*OW-1:0] harm_pow;
  logic [H*BW-1:0] harm_peak;
  logic [OW-1:0] sig_pow, total_pow;
  logic [SW-1:0] harm_sum;
  logic [MW-1:0] spur_mag;
  logic [BW-1:0] spur_bin, fund_lo, fund_hi;

  logic [MW-1:0] mem [NB];
  always_ff @(posedge clk) rd_data <= mem[rd_addr];

  always #5 clk = ~clk;

  harmonic_power_scan #(.NBINS(NB), .MAG_W(MW), .H_MAX(H)) i_harmonic_power_scan (
    .clk(clk), .rst(rst), .start(start), .fund_bin(fund_bin), .harm_cnt(harm_cnt),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .harm_pow(harm_pow),
    .harm_peak(harm_peak), .sig_pow(sig_pow), .harm_sum(harm_sum),
    .total_pow(total_pow), .spur_mag(spur_mag), .spur_bin(spur_bin),
    .fund_lo(fund_lo), .fund_hi(fund_hi)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  longint e_pow [H];
  int     e_peak [H];
  longint e_sig, e_hs, e_tot;
  int     e_spm, e_spb, e_fl, e_fu;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sq(int v);
    return longint'(v) * longint'(v);
  endfunction

  // Reference model written from the requirements
  task automatic model(int f, int c);
    int cc;
    cc = (c == 0) ? 1 : ((c > H) ? H : c);
    for (int j = 0; j < H; j++) begin e_pow[j] = 0; e_peak[j] = 0; end
    e_sig = 0; e_hs = 0; e_tot = 0; e_spm = 0; e_spb = 0; e_fl = 0; e_fu = 0;
    for (int hh = 1; hh <= cc; hh++) begin
      int k, e, lo, hi, p, l, u;
      longint s;
      bit dup;
      k  = (hh * f) % (2 * NB);                      // R3 fold
      e  = (k <= NB) ? k : 2 * NB - k;
      lo = (e - 5 < 1) ? 1 : e - 5;                  // R4 window
      hi = (e + 5 > NB - 1) ? NB - 1 : e + 5;
      p  = lo;
      for (int b = lo; b <= hi; b++) if (mem[b] > mem[p]) p = b;
      l = p;
      while (l > 1 && mem[l-1] < mem[l]) l--;        // R5 walk
      u = p;
      while (u < NB - 1 && mem[u+1] < mem[u]) u++;
      s = 0;
      for (int b = l; b <= u; b++) s += sq(int'(mem[b]));
      dup = 1'b0;
      for (int j = 0; j < hh - 1; j++) if (e_peak[j] == p) dup = 1'b1;
      e_peak[hh-1] = p;
      e_pow[hh-1]  = dup ? 0 : 2 * s;                // R6, R7
      if (hh == 1) begin e_sig = e_pow[0]; e_fl = l; e_fu = u; end
      else e_hs += e_pow[hh-1];
    end
    for (int b = 1; b < NB; b++) begin
      e_tot += 2 * sq(int'(mem[b]));                 // R10
      if ((b < e_fl || b > e_fu) && int'(mem[b]) > e_spm) begin
        e_spm = int'(mem[b]); e_spb = b;             // R11
      end
    end
  endtask

  task automatic fill_noise(int amp);
    for (int b = 0; b < NB; b++) mem[b] = MW'($urandom % amp);
  endtask

  task automatic tone(int b, int a);
    for (int d = -2; d <= 2; d++) begin
      int x, v;
      x = b + d;
      v = a >> ((d < 0) ? -d : d);
      if (x >= 1 && x < NB && v > int'(mem[x])) mem[x] = MW'(v);
    end
  endtask

  task automatic pulse_start(int f, int c);
    @(negedge clk);
    fund_bin = BW'(f);
    harm_cnt = HW'(c);
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic run_case(int f, int c, string nm, bit poke);
    int t;
    model(f, c);
    pulse_start(f, c);
    if (poke) begin
      repeat (15) @(negedge clk);
      pulse_start((f + 7) % NB, 2);                  // R12 ignored while busy
    end
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done, {"R12 done rises ", nm}, done, 1);
    for (int j = 0; j < H; j++) begin
      chk(harm_pow[j*OW +: OW] == OW'(e_pow[j]), {"R6 R7 R8 harmonic power ", nm},
          longint'(harm_pow[j*OW +: OW]), e_pow[j]);
      chk(int'(harm_peak[j*BW +: BW]) == e_peak[j], {"R3 R4 peak bin ", nm},
          longint'(harm_peak[j*BW +: BW]), e_peak[j]);
    end
    chk(sig_pow == OW'(e_sig), {"R8 signal power ", nm}, longint'(sig_pow), e_sig);
    chk(harm_sum == SW'(e_hs), {"R8 harmonic sum ", nm}, longint'(harm_sum), e_hs);
    chk(total_pow == OW'(e_tot), {"R10 total power ", nm}, longint'(total_pow), e_tot);
    chk(int'(fund_lo) == e_fl && int'(fund_hi) == e_fu, {"R5 fundamental span ", nm},
        longint'(fund_lo) * 100 + fund_hi, longint'(e_fl) * 100 + e_fu);
    chk(int'(spur_mag) == e_spm, {"R11 spur magnitude ", nm}, longint'(spur_mag), e_spm);
    chk(int'(spur_bin) == e_spb, {"R11 spur bin ", nm}, longint'(spur_bin), e_spb);
    @(negedge clk);
    chk(done && total_pow == OW'(e_tot), {"R12 outputs hold ", nm}, longint'(total_pow), e_tot);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int b = 0; b < NB; b++) mem[b] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state, R2 address start
    chk(!done && total_pow == '0 && sig_pow == '0 && spur_mag == '0, "R1 reset outputs",
        longint'(total_pow), 0);
    chk(rd_addr == BW'(1), "R1 R2 reset address", longint'(rd_addr), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(!done, "R1 idle after reset", done, 0);

    // Low fundamental, all harmonics, big DC bin (R10 exclusion)
    fill_noise(8);
    mem[0] = MW'(4000);
    for (int hh = 1; hh <= 9; hh++) tone(5 * hh, 3000 / hh);
    run_case(5, 9, "low fundamental", 1'b0);

    // Folding near the top of the band (R3)
    fill_noise(8);
    tone(50, 3500); tone(28, 900); tone(22, 700); tone(56, 500);
    run_case(50, 4, "folded harmonics", 1'b0);

    // Nyquist edge, DC alias and repeats of the fundamental peak (R7)
    fill_noise(6);
    tone(32, 3000); tone(63, 800); tone(1, 600);
    run_case(32, 5, "duplicate peaks", 1'b0);

    // Count 0 clamps to 1 (R9), window clipped at bin 1
    fill_noise(10);
    tone(1, 2000);
    run_case(1, 0, "count zero", 1'b0);

    // Count above limit clamps (R9)
    fill_noise(10);
    tone(63, 2500);
    run_case(63, 15, "count over limit", 1'b0);

    // Flat spectrum: ties to lowest bin, no walk across plateau (R4, R5, R11)
    for (int b = 0; b < NB; b++) mem[b] = MW'(100);
    run_case(10, 3, "flat spectrum", 1'b0);

    // Start while busy is ignored (R12)
    fill_noise(20);
    tone(7, 3000); tone(14, 1000);
    run_case(7, 3, "start while busy", 1'b1);

    // Random spectra and counts
    for (int r = 0; r < 8; r++) begin
      int f, c;
      f = 1 + int'($urandom % (NB - 1));
      c = int'($urandom % 12);
      fill_noise(1 + int'($urandom % 200));
      for (int hh = 1; hh <= 4; hh++) begin
        int k, e;
        k = (hh * f) % (2 * NB);
        e = (k <= NB) ? k : 2 * NB - k;
        if (e >= 1 && e < NB) tone(e + int'($urandom % 3) - 1, 200 + int'($urandom % 3800));
      end
      run_case(f, c, "random", 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule